// File: doc/BRIEF.md
# Synchronized Leading/Trailing Edge Dual Modulator

This block drives the two power switches of a two-stage converter: a boost front end that shapes the line current and a back-end DC-DC stage. A single free-running counter supplies the timebase. Each turn of the counter is one back-end period, made of a ramp interval followed by a short dead interval. A toggle bit that flips at every counter wrap marks even and odd periods. The front-end cycle therefore spans exactly two back-end periods and always begins together with a back-end period.

The back end uses trailing-edge control. Its gate rises at the start of its period and falls once the count reaches its on-length. The on-length is the command minus a built-in offset, capped just below half the period. The front end uses leading-edge control. Its gate is forced low at the start of its cycle and rises when the ramp position reaches a threshold derived from its command. The threshold never drops below a minimum off-time, and a crossing that falls inside a dead interval is held off until the next ramp interval. So at the shared clock instant, the front-end switch turns off just as the back-end switch turns on. Each stage latches its own current-limit strobe and holds its gate low until its next cycle start. Commands and enables are captured only at cycle starts.

Top module: `dual_edge_modulator`

## Requirements
- R1: While reset is asserted, both gates and both start strobes are low. The first clock edge after reset release begins a back-end period and a front-end cycle together.
- R2: `pwm_start_o` is high for one clock in every 2^CNT_W clocks, when the count is 0. `pfc_start_o` is high on every second of those clocks only, and is never high without `pwm_start_o`.
- R3: The back-end gate is high for the first N clocks of its period and low for the rest, where N = min(cmd − PWM_OFFSET, PWM_MAX_ON) (default offset 43, default cap 120 of 256).
- R4: A back-end command at or below PWM_OFFSET gives a period with no pulse. A command of PWM_OFFSET+1 gives a one-clock pulse.
- R5: The back-end on-time never exceeds PWM_MAX_ON = floor(2^CNT_W · PWM_MAX_PCT / 100) clocks, which is below half the period.
- R6: The front-end gate is low from its cycle start. It rises when the position p (0 to 2^(CNT_W+1)−1 within the cycle) first reaches T = max(2·(2^CNT_W − 1 − cmd), PFC_MIN_OFF) while in a ramp interval, and stays high until the next front-end start.
- R7: The front-end gate is low for at least PFC_MIN_OFF = ceil(2^(CNT_W+1) · (100 − PFC_MAX_PCT) / 100) clocks of every cycle (31 by default).
- R8: The last DEAD_CYC clocks of each back-end period form a dead interval. A front-end threshold that falls there takes effect at the next ramp interval, or not at all in the cycle's final dead interval.
- R9: Commands and enables are sampled only at the clock edge that starts the stage's own cycle. Changes at any other time have no effect until then.
- R10: A stage whose enable was low at its cycle start keeps its gate low for that whole cycle.
- R11: A back-end fault strobe seen at a clock edge forces the back-end gate low from that edge up to the next back-end start, where normal behaviour resumes.
- R12: A front-end fault strobe forces the front-end gate low up to the next front-end start. It is not cleared by a back-end start in between.
- R13: A fault strobe seen at the same edge as a cycle start wins over the clear, and the gate stays low for the whole cycle that begins there.
- R14: At a front-end cycle start, the front-end gate falls on the same edge on which the back-end gate rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pfc_cmd_i | input | CNT_W | Front-end duty command, unsigned, on the ramp scale |
| pwm_cmd_i | input | CNT_W | Back-end duty command, unsigned, includes offset |
| pfc_en_i | input | 1 | Front-end enable from supervisor |
| pwm_en_i | input | 1 | Back-end enable from supervisor |
| pfc_flt_i | input | 1 | Front-end current-limit strobe |
| pwm_flt_i | input | 1 | Back-end current-limit strobe |
| pfc_gate_o | output | 1 | Front-end switch drive |
| pwm_gate_o | output | 1 | Back-end switch drive |
| pfc_start_o | output | 1 | Front-end cycle-start strobe |
| pwm_start_o | output | 1 | Back-end cycle-start strobe |

## Verification
The bench targets several corner cases.

- **Front-end threshold in a dead interval.** Thresholds that land in the first dead interval, and commands whose crossing lands in the final one, are exercised. A design that ignored dead time would raise the gate early or emit a short sliver before the edge that forces it low.
- **Offset and cap boundaries.** Commands sit exactly at the offset, one above it, and at and above the cap. An off-by-one error shows as a stray one-clock pulse or a pulse wider than the cap.
- **Fault clearing.** A front-end fault is placed before the mid-cycle back-end start. A design that clears it at the wrong start re-enables the gate too early.
- **Fault on a start edge.** Strobes that coincide with a start edge catch a clear-first latch.
- **Mid-cycle input changes.** Commands and enables are scrambled in mid-cycle, which exposes any design that samples inputs continuously.

// File: rtl/dem_pkg.sv
package dem_pkg;

    typedef enum logic {
        EDGE_TRAIL = 1'b0,
        EDGE_LEAD  = 1'b1
    } edge_kind_e;

endpackage

// File: rtl/dem_ramp_gen.sv
module dem_ramp_gen #(
    parameter int CNT_W    = 8,
    parameter int DEAD_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_d_o,
    output logic [CNT_W:0]   pos_d_o,
    output logic             ramp_d_o,
    output logic             pwm_start_d_o,
    output logic             pfc_start_d_o,
    output logic             pwm_start_o,
    output logic             pfc_start_o
);

    localparam int PERIOD = 1 << CNT_W;
    localparam logic [CNT_W-1:0] RAMP_LEN_C = CNT_W'(PERIOD - DEAD_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
        logic             pwm_start;
        logic             pfc_start;
    } ramp_st_t;

    ramp_st_t st_d, st_q;
    logic     wrap;

    always_comb begin
        wrap         = &st_q.cnt;
        st_d         = st_q;
        st_d.cnt     = st_q.cnt + 1'b1;
        st_d.phase   = st_q.phase ^ wrap;
        st_d.pwm_start = wrap;
        st_d.pfc_start = wrap & st_q.phase;
    end

    // Reset parks the counter on its last count with the toggle set, so the
    // first edge after release starts both stages together.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt       <= '1;
            st_q.phase     <= 1'b1;
            st_q.pwm_start <= 1'b0;
            st_q.pfc_start <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_d_o       = st_d.cnt;
    assign pos_d_o       = {st_d.phase, st_d.cnt};
    assign ramp_d_o      = (st_d.cnt < RAMP_LEN_C);
    assign pwm_start_d_o = st_d.pwm_start;
    assign pfc_start_d_o = st_d.pfc_start;
    assign pwm_start_o   = st_q.pwm_start;
    assign pfc_start_o   = st_q.pfc_start;

    assert_pfc_in_pwm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pfc_start |-> st_q.pwm_start);

    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pwm_start |=> !st_q.pwm_start);

endmodule

// File: rtl/dem_edge_stage.sv
module dem_edge_stage
    import dem_pkg::*;
#(
    parameter edge_kind_e KIND    = EDGE_TRAIL,
    parameter int         CNT_W   = 8,
    parameter int         POS_W   = 8,
    parameter int         OFFSET  = 0,
    parameter int         MAX_ON  = 1,
    parameter int         MIN_OFF = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_d_i,
    input  logic [POS_W-1:0] pos_d_i,
    input  logic             ramp_d_i,
    input  logic [CNT_W-1:0] cmd_i,
    input  logic             en_i,
    input  logic             flt_i,
    output logic             gate_o
);

    typedef struct packed {
        logic [POS_W-1:0] thr;
        logic             en;
        logic             flt;
        logic             on;
        logic             gate;
        logic             start;
        logic             ramp;
        logic [POS_W-1:0] pos;
    } stage_st_t;

    stage_st_t        st_d, st_q;
    logic [POS_W-1:0] thr_new;
    logic [POS_W-1:0] thr_sel;
    logic             on_next;

    assign thr_sel = start_d_i ? thr_new : st_q.thr;

    generate
        if (KIND == EDGE_TRAIL) begin : g_trail
            localparam logic [POS_W:0]   OFF_C = (POS_W + 1)'(OFFSET);
            localparam logic [POS_W:0]   MAX_C = (POS_W + 1)'(MAX_ON);
            localparam logic [POS_W-1:0] MAX_T = POS_W'(MAX_ON);
            logic [POS_W:0] cmd_x;
            logic [POS_W:0] diff;

            always_comb begin
                cmd_x = (POS_W + 1)'(cmd_i);
                diff  = cmd_x - OFF_C;
                if (cmd_x > OFF_C)
                    thr_new = (diff > MAX_C) ? MAX_T : diff[POS_W-1:0];
                else
                    thr_new = '0;
                // On from cycle start until the ramp reaches the on-length.
                on_next = (start_d_i | st_q.on) & ramp_d_i & (pos_d_i < thr_sel);
            end

            assert_trail_rise_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(st_q.gate) |-> st_q.start);

            assert_trail_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.gate |-> (st_q.pos < MAX_T));
        end else begin : g_lead
            localparam logic [POS_W-1:0] MIN_T = POS_W'(MIN_OFF);
            logic [POS_W-1:0] lead_raw;

            always_comb begin
                lead_raw = POS_W'({~cmd_i, 1'b0});
                thr_new  = (lead_raw < MIN_T) ? MIN_T : lead_raw;
                // Off from cycle start; on once the ramp crosses the threshold.
                on_next  = start_d_i ? 1'b0
                                     : (st_q.on | (ramp_d_i & (pos_d_i >= thr_sel)));
            end

            assert_lead_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(st_q.gate) |-> (st_q.start || st_q.flt));

            assert_lead_min_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.gate |-> (st_q.pos >= MIN_T));

            assert_lead_rise_in_ramp_R8: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(st_q.gate) |-> st_q.ramp);
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.start = start_d_i;
        st_d.ramp  = ramp_d_i;
        st_d.pos   = pos_d_i;
        if (start_d_i) begin
            st_d.thr = thr_new;
            st_d.en  = en_i;
        end
        st_d.flt  = flt_i | (st_q.flt & ~start_d_i);
        st_d.on   = on_next;
        st_d.gate = st_d.en & ~st_d.flt & st_d.on;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o = st_q.gate;

    assert_fault_blanks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flt_i) |-> !st_q.gate);

endmodule

// File: rtl/dual_edge_modulator.sv
module dual_edge_modulator
    import dem_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int DEAD_CYC    = 4,
    parameter int PWM_OFFSET  = 43,
    parameter int PWM_MAX_PCT = 47,
    parameter int PFC_MAX_PCT = 94
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] pfc_cmd_i,
    input  logic [CNT_W-1:0] pwm_cmd_i,
    input  logic             pfc_en_i,
    input  logic             pwm_en_i,
    input  logic             pfc_flt_i,
    input  logic             pwm_flt_i,
    output logic             pfc_gate_o,
    output logic             pwm_gate_o,
    output logic             pfc_start_o,
    output logic             pwm_start_o
);

    localparam int PERIOD      = 1 << CNT_W;
    localparam int PWM_MAX_ON  = (PERIOD * PWM_MAX_PCT) / 100;
    localparam int PFC_MIN_OFF = (2 * PERIOD * (100 - PFC_MAX_PCT) + 99) / 100;

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W:0]   pos_d;
    logic             ramp_d;
    logic             pwm_start_d;
    logic             pfc_start_d;

    dem_ramp_gen #(
        .CNT_W    (CNT_W),
        .DEAD_CYC (DEAD_CYC)
    ) u_ramp (
        .clk           (clk),
        .rst_n         (rst_n),
        .cnt_d_o       (cnt_d),
        .pos_d_o       (pos_d),
        .ramp_d_o      (ramp_d),
        .pwm_start_d_o (pwm_start_d),
        .pfc_start_d_o (pfc_start_d),
        .pwm_start_o   (pwm_start_o),
        .pfc_start_o   (pfc_start_o)
    );

    dem_edge_stage #(
        .KIND    (EDGE_TRAIL),
        .CNT_W   (CNT_W),
        .POS_W   (CNT_W),
        .OFFSET  (PWM_OFFSET),
        .MAX_ON  (PWM_MAX_ON),
        .MIN_OFF (1)
    ) u_back (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_d_i (pwm_start_d),
        .pos_d_i   (cnt_d),
        .ramp_d_i  (ramp_d),
        .cmd_i     (pwm_cmd_i),
        .en_i      (pwm_en_i),
        .flt_i     (pwm_flt_i),
        .gate_o    (pwm_gate_o)
    );

    dem_edge_stage #(
        .KIND    (EDGE_LEAD),
        .CNT_W   (CNT_W),
        .POS_W   (CNT_W + 1),
        .OFFSET  (0),
        .MAX_ON  (1),
        .MIN_OFF (PFC_MIN_OFF)
    ) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_d_i (pfc_start_d),
        .pos_d_i   (pos_d),
        .ramp_d_i  (ramp_d),
        .cmd_i     (pfc_cmd_i),
        .en_i      (pfc_en_i),
        .flt_i     (pfc_flt_i),
        .gate_o    (pfc_gate_o)
    );

endmodule

// File: tb/dual_edge_modulator_test.sv
`timescale 1ns/1ps
module dual_edge_modulator_test;

    localparam int PERIOD  = 256;
    localparam int RAMP    = 252;
    localparam int OFFS    = 43;
    localparam int CAP     = 120;
    localparam int MINOFF  = 31;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pfc_cmd_i = '0, pwm_cmd_i = '0;
    logic       pfc_en_i = 1'b0, pwm_en_i = 1'b0;
    logic       pfc_flt_i = 1'b0, pwm_flt_i = 1'b0;
    logic       pfc_gate_o, pwm_gate_o, pfc_start_o, pwm_start_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // bench model state
    int m_pwm_thr = 0, m_pfc_thr = 0;
    bit m_pwm_en = 0, m_pfc_en = 0, m_pwm_flt = 0, m_pfc_flt = 0, m_pfc_on = 0;
    bit s_pwm = 0, s_pfc = 0;

    always #5 clk = ~clk;

    dual_edge_modulator uut (
        .clk(clk), .rst_n(rst_n),
        .pfc_cmd_i(pfc_cmd_i), .pwm_cmd_i(pwm_cmd_i),
        .pfc_en_i(pfc_en_i), .pwm_en_i(pwm_en_i),
        .pfc_flt_i(pfc_flt_i), .pwm_flt_i(pwm_flt_i),
        .pfc_gate_o(pfc_gate_o), .pwm_gate_o(pwm_gate_o),
        .pfc_start_o(pfc_start_o), .pwm_start_o(pwm_start_o)
    );

    function automatic int pwm_len(input int cmd);
        int v;
        v = cmd - OFFS;
        if (v < 0) v = 0;
        if (v > CAP) v = CAP;
        return v;
    endfunction

    function automatic int pfc_thr(input int cmd);
        int t;
        t = 2 * (PERIOD - 1 - cmd);
        if (t < MINOFF) t = MINOFF;
        return t;
    endfunction

    task automatic chk(input string tag, input string what, input int k,
                       input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s at pos %0d: actual %0d expected %0d", tag, what, k, act, exp);
        end
    endtask

    // One front-end cycle (two back-end periods). Entered at the negedge just
    // before the edge that begins the cycle; inputs set here are latched there.
    task automatic frame(input int pfc_c, input int pwm_c0, input int pwm_c1,
                         input bit pfc_e, input bit pwm_e,
                         input int pfc_f_at, input int pwm_f_at, input string tag);
        pfc_cmd_i = 8'(pfc_c);
        pwm_cmd_i = 8'(pwm_c0);
        pfc_en_i  = pfc_e;
        pwm_en_i  = pwm_e;
        for (int k = 0; k < 2 * PERIOD; k++) begin
            int  c;
            bit  ramp, e_pwm, e_pfc;
            @(negedge clk);
            c = k % PERIOD;
            ramp = (c < RAMP);
            if (c == 0) begin
                m_pwm_thr = pwm_len(int'(pwm_cmd_i));
                m_pwm_en  = pwm_en_i;
            end
            if (k == 0) begin
                m_pfc_thr = pfc_thr(int'(pfc_cmd_i));
                m_pfc_en  = pfc_en_i;
                m_pfc_on  = 1'b0;
            end
            m_pwm_flt = s_pwm | (m_pwm_flt & (c != 0));
            m_pfc_flt = s_pfc | (m_pfc_flt & (k != 0));
            if (ramp && k >= m_pfc_thr) m_pfc_on = 1'b1;
            e_pwm = m_pwm_en && !m_pwm_flt && ramp && (c < m_pwm_thr);
            e_pfc = m_pfc_en && !m_pfc_flt && m_pfc_on;
            chk(tag, "pwm_gate", k, int'(pwm_gate_o), int'(e_pwm));
            chk(tag, "pfc_gate", k, int'(pfc_gate_o), int'(e_pfc));
            chk("R2", "pwm_start", k, int'(pwm_start_o), int'(c == 0));
            chk("R2", "pfc_start", k, int'(pfc_start_o), int'(k == 0));
            // drive for this cycle
            pwm_flt_i = (k == pwm_f_at);
            pfc_flt_i = (k == pfc_f_at);
            s_pwm = pwm_flt_i;
            s_pfc = pfc_flt_i;
            if (k == 20 || k == 300) begin
                // R9: mid-cycle scramble must not matter
                pwm_cmd_i = 8'($urandom);
                pfc_cmd_i = 8'($urandom);
                pwm_en_i  = 1'($urandom);
                pfc_en_i  = 1'($urandom);
            end
            if (k == PERIOD - 1) begin
                pwm_cmd_i = 8'(pwm_c1);
                pwm_en_i  = pwm_e;
            end
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "pwm_gate in reset", 0, int'(pwm_gate_o), 0);
        chk("R1", "pfc_gate in reset", 0, int'(pfc_gate_o), 0);
        chk("R1", "pwm_start in reset", 0, int'(pwm_start_o), 0);
        chk("R1", "pfc_start in reset", 0, int'(pfc_start_o), 0);
        rst_n = 1'b1;
        // R1: first cycle after release starts both stages (checked in frame)
        frame(200, 100, 60, 1, 1, -1, -1, "R3");
        frame(128, 43, 44, 1, 1, -1, -1, "R4");   // pfc threshold 254 -> R8 too
        frame(128, 200, 44, 1, 1, -1, -1, "R8");
        frame(250, 255, 163, 1, 1, -1, -1, "R5");
        frame(2, 164, 150, 1, 1, -1, -1, "R6");
        frame(255, 0, 0, 1, 1, -1, -1, "R7");
        frame(240, 100, 100, 1, 1, -1, -1, "R7");
        frame(0, 120, 120, 1, 1, -1, -1, "R8");
        frame(1, 120, 120, 1, 1, -1, -1, "R8");
        frame(250, 150, 150, 0, 1, -1, -1, "R10");
        frame(250, 150, 150, 1, 0, -1, -1, "R10");
        frame(220, 150, 150, 1, 1, -1, 30, "R11");
        frame(250, 150, 150, 1, 1, 100, -1, "R12");
        frame(250, 150, 150, 1, 1, 511, 255, "R13");
        frame(250, 150, 150, 1, 1, -1, 511, "R13");
        frame(250, 150, 150, 1, 1, -1, -1, "R14");
        for (int i = 0; i < 16; i++) begin
            int fa, fb;
            fa = ($urandom % 4 == 0) ? int'($urandom % 512) : -1;
            fb = ($urandom % 4 == 0) ? int'($urandom % 512) : -1;
            frame(int'($urandom % 256), int'($urandom % 256), int'($urandom % 256),
                  ($urandom % 8) != 0, ($urandom % 8) != 0, fa, fb, "R9");
        end
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule